// File: doc/BRIEF.md
# Flagged Shift Unit

A combinational 16-bit shift stage for a small register machine's datapath. It moves a single operand left by one place, right by one place or right by four places, and fills the vacated positions as an arithmetic, unsigned or cyclic shift. Alongside the shifted word it produces a carry flag and an overflow flag. Both flags describe the bits that the shift discarded, so a program can detect lost precision after scaling a value.

The shift direction, the right-shift distance and the fill mode come straight from decoded instruction fields. The result and both flags settle in the same cycle as the operand. The sign and nonzero status bits are not produced here; the surrounding datapath derives them from the result.

Top module: `shift_flag_unit`

## Requirements
- R1: With dir_i=0 (left by one) and mode_i[1]=0, res_o equals the operand moved up one place with bit 0 cleared.
- R2: On a left shift, k_o equals the operand's bit 15, which is the bit pushed off the top.
- R3: On a left shift, v_o is 1 exactly when doubling the operand as a signed 16-bit value leaves the range -32768..32767, which means bits 15 and 14 differ.
- R4: With dir_i=1 and far_i=0 (right by one), k_o equals operand bit 0 and v_o is 0.
- R5: With dir_i=1 and far_i=1 (right by four), k_o equals operand bit 3, the last bit dropped, and v_o is the OR of operand bits 2..0.
- R6: mode_i=2'b00 (arithmetic) on a right shift fills the vacated top positions with operand bit 15.
- R7: mode_i=2'b01 (unsigned) on a right shift fills the vacated top positions with zeros.
- R8: mode_i=2'b10 or 2'b11 (cyclic) rotates the operand in the selected direction, so the bits shifted out re-enter at the opposite end.
- R9: k_o and v_o depend only on the operand, dir_i and far_i, and are the same in every fill mode.
- R10: far_i has no effect on res_o, k_o or v_o while dir_i=0.
- R11: The block holds no state, and res_o, k_o and v_o follow a change of input without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 16 | Operand to shift |
| dir_i | input | 1 | 0 = left by one, 1 = right |
| far_i | input | 1 | Right distance: 0 = one place, 1 = four places; ignored on left |
| mode_i | input | 2 | Fill mode: 00 arithmetic, 01 unsigned, 1x cyclic |
| res_o | output | 16 | Shifted word |
| k_o | output | 1 | Carry flag for the discarded bits |
| v_o | output | 1 | Overflow flag for the discarded bits |

## Verification
The checker assumes that every input carries a known 0/1 value. It skips any evaluation in which an input or output is unknown, so values seen before the bench first drives the ports raise nothing. The bench drives every port from its first cycle and changes the inputs only on the falling clock edge. Every fill mode and shift kind, including both cyclic codes and both far_i values on left shifts, is applied against each operand in a 4096-value sweep and a set of sign-boundary operands.

// File: rtl/shift_flag_pkg.sv
package shift_flag_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned FAR_AMT = 4;

  typedef enum logic [1:0] {
    FILL_ARITH = 2'b00,
    FILL_UNS   = 2'b01,
    FILL_CYC   = 2'b10,
    FILL_CYC_B = 2'b11
  } fill_e;
endpackage

// File: rtl/shl_stage.sv
module shl_stage #(
  parameter int unsigned W   = 16,
  parameter int unsigned AMT = 1
) (
  input  logic [W-1:0] d_i,
  input  logic         cyc_i,
  output logic [W-1:0] q_o,
  output logic         k_o,
  output logic         v_o
);
  localparam int unsigned TOP = W - AMT;

  logic [AMT-1:0] lost;
  logic [AMT:0]   top_win;

  assign lost    = d_i[W-1:TOP];
  assign top_win = d_i[W-1:TOP-1];

  always_comb begin
    q_o = {d_i[TOP-1:0], (cyc_i ? lost : {AMT{1'b0}})};
    k_o = |lost;
    // signed scaling overflows unless the window is all equal to the new sign
    v_o = !((&top_win) || !(|top_win));
  end
endmodule

// File: rtl/shr_stage.sv
module shr_stage
  import shift_flag_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned AMT = 1
) (
  input  logic [W-1:0] d_i,
  input  fill_e        mode_i,
  output logic [W-1:0] q_o,
  output logic         k_o,
  output logic         v_o
);
  logic [AMT-1:0] fill;

  always_comb begin
    unique case (mode_i)
      FILL_ARITH:         fill = {AMT{d_i[W-1]}};
      FILL_UNS:           fill = '0;
      FILL_CYC, FILL_CYC_B: fill = d_i[AMT-1:0];
      default:            fill = '0;
    endcase
    q_o = {fill, d_i[W-1:AMT]};
  end

  assign k_o = d_i[AMT-1];

  generate
    if (AMT > 1) begin : g_multi
      assign v_o = |d_i[AMT-2:0];
    end else begin : g_single
      assign v_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_flag_pkg::*;
#(
  parameter int unsigned W       = WORD_W,
  parameter int unsigned FAR_SHR = FAR_AMT
) (
  input  logic [W-1:0] opnd_i,
  input  logic         dir_i,
  input  logic         far_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] res_o,
  output logic         k_o,
  output logic         v_o
);
  localparam int unsigned N_RIGHT = 2;

  fill_e mode;
  assign mode = fill_e'(mode_i);

  logic [W-1:0] l_q;
  logic         l_k, l_v;
  logic [W-1:0] r_q [N_RIGHT];
  logic [N_RIGHT-1:0] r_k, r_v;

  shl_stage #(.W(W), .AMT(1)) u_shl (
    .d_i  (opnd_i),
    .cyc_i(mode_i[1]),
    .q_o  (l_q),
    .k_o  (l_k),
    .v_o  (l_v)
  );

  for (genvar g = 0; g < N_RIGHT; g++) begin : g_shr
    localparam int unsigned AMT = (g == 0) ? 1 : FAR_SHR;
    shr_stage #(.W(W), .AMT(AMT)) u_shr (
      .d_i   (opnd_i),
      .mode_i(mode),
      .q_o   (r_q[g]),
      .k_o   (r_k[g]),
      .v_o   (r_v[g])
    );
  end

  always_comb begin
    if (!dir_i) begin
      res_o = l_q;
      k_o   = l_k;
      v_o   = l_v;
    end else begin
      res_o = r_q[far_i];
      k_o   = r_k[far_i];
      v_o   = r_v[far_i];
    end
  end
endmodule

// File: rtl/shift_flag_unit_chk.sv
module shift_flag_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic [W-1:0] opnd_i,
  input logic         dir_i,
  input logic         far_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] res_o,
  input logic         k_o,
  input logic         v_o
);
  logic known;
  assign known = !$isunknown({opnd_i, dir_i, far_i, mode_i, res_o, k_o, v_o});

  always_comb begin
    if (known) begin
      if (!dir_i) begin
        a_r2_left_carry: assert (k_o == opnd_i[W-1]);
        a_r3_left_ovf: assert (v_o == (opnd_i[W-1] != opnd_i[W-2]));
        if (!mode_i[1]) begin
          a_r1_left_zero_in: assert (res_o[0] == 1'b0);
        end
      end else begin
        a_r6_r7_top_kept: assert (res_o[W-5:0] == opnd_i[W-1:4] || !far_i);
        if (!far_i) begin
          a_r4_no_overflow: assert (!v_o && k_o == opnd_i[0]);
        end else begin
          a_r5_far_flags: assert (k_o == opnd_i[3] && v_o == (opnd_i[2:0] != 3'b000));
        end
        if (mode_i == 2'b00) begin
          a_r6_sign_kept: assert (res_o[W-1] == opnd_i[W-1]);
        end
        if (mode_i == 2'b01) begin
          a_r7_zero_top: assert (res_o[W-1] == 1'b0);
        end
      end
      if (mode_i[1]) begin
        a_r8_bits_conserved: assert ($countones(res_o) == $countones(opnd_i));
      end
    end
  end
endmodule

bind shift_flag_unit shift_flag_unit_chk #(.W(W)) u_chk (.*);

// File: tb/shift_flag_unit_bench.sv
`timescale 1ns/1ps
module shift_flag_unit_bench;
  logic        clk = 1'b0;
  logic [15:0] opnd;
  logic        dir, far;
  logic [1:0]  mode;
  logic [15:0] res;
  logic        k, v;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  shift_flag_unit u_shift_flag_unit (
    .opnd_i(opnd), .dir_i(dir), .far_i(far), .mode_i(mode),
    .res_o(res), .k_o(k), .v_o(v)
  );

  function automatic string req_of(input logic d, input logic f, input logic [1:0] m, input int part);
    if (part == 1) return !d ? "R2/R9" : (f ? "R5/R9" : "R4/R9");
    if (part == 2) return !d ? "R3/R9" : (f ? "R5/R9" : "R4/R9");
    if (m[1]) return "R8";
    if (!d) return f ? "R10/R1" : "R1";
    return m[0] ? "R7" : "R6";
  endfunction

  task automatic apply(input logic [15:0] o, input logic d, input logic f, input logic [1:0] m);
    logic [15:0] e_res;
    logic        e_k, e_v;
    int          amt, dbl;
    @(negedge clk);
    opnd = o; dir = d; far = f; mode = m;
    #2;
    amt = d ? (f ? 4 : 1) : 1;
    if (!d) begin
      e_res = m[1] ? 16'((o << 1) | (o >> 15)) : 16'(o << 1);
      e_k = o[15];
      dbl = 2 * int'($signed(o));
      e_v = (dbl > 32767) || (dbl < -32768);
    end else begin
      if (m[1]) e_res = 16'((o >> amt) | (o << (16 - amt)));
      else if (m[0]) e_res = o >> amt;
      else e_res = 16'($signed(o) >>> amt);
      e_k = o[amt-1];
      e_v = f ? ((o & 16'h7) != 0) : 1'b0;
    end
    n_vec++;
    if (res !== e_res || k !== e_k || v !== e_v) begin
      n_bad++;
      if (res !== e_res)
        $display("FAIL %s res op=%h dir=%0b far=%0b mode=%0d got %h exp %h",
                 req_of(d, f, m, 0), o, d, f, m, res, e_res);
      if (k !== e_k)
        $display("FAIL %s k op=%h dir=%0b far=%0b mode=%0d got %0b exp %0b",
                 req_of(d, f, m, 1), o, d, f, m, k, e_k);
      if (v !== e_v)
        $display("FAIL %s v op=%h dir=%0b far=%0b mode=%0d got %0b exp %0b",
                 req_of(d, f, m, 2), o, d, f, m, v, e_v);
    end
  endtask

  task automatic all_kinds(input logic [15:0] o);
    for (int c = 0; c < 16; c++)
      apply(o, c[3], c[2], c[1:0]);
  endtask

  initial begin
    opnd = '0; dir = 1'b0; far = 1'b0; mode = 2'b00;
    // R11: no clock edge has passed, outputs already reflect the zero operand
    #1;
    n_vec++;
    if (res !== 16'h0 || k !== 1'b0 || v !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 initial got res=%h k=%0b v=%0b exp 0000 0 0", res, k, v);
    end
    // sign and flag boundaries: R3 overflow edges, R5 low-nibble cases
    all_kinds(16'h0000); all_kinds(16'hFFFF);
    all_kinds(16'h8000); all_kinds(16'h7FFF);
    all_kinds(16'h4000); all_kinds(16'hC000);
    all_kinds(16'hBFFF); all_kinds(16'h0008);
    all_kinds(16'h0007); all_kinds(16'h0001);
    for (int i = 0; i < 4096; i++)
      all_kinds(16'(i * 40503 + 17));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule